// File: doc/BRIEF.md
# Image Directory Walker and Payload Checker

This block takes over a flash byte stream at byte offset 16, after the header and its checksums have been handled elsewhere. A `start` pulse supplies the image count and the expected payload checksum. The block then reads one 12-byte directory entry per image, stores each entry's identifier, start offset and length in a small register table, and follows the image data that comes after the directory. On the way it checks where each image is placed and that it is 4-byte aligned, checks that every filler byte is zero, and runs a reflected CRC-32 over the payload.

The walk ends at the first structural problem found, or after the last byte of the last image. A one-cycle `done` pulse reports the result, and a 3-bit result code is held until the next `start`. A lookup port lets later boot logic ask for an identifier and get the offset and size of the matching image one cycle later.

Top module: `img_dir_walker`

## Requirements
- R1: While reset is asserted and just after it, `busy`, `done`, `lk_hit` and `err_code` are all 0.
- R2: On `start` with an image count above MAX_IMG (default 8), `done` is 1 in the next cycle and `err_code` = 1. With a count of 0, `done` is 1 in the next cycle and `err_code` is 0 if the expected checksum is 0x00000000, otherwise 5.
- R3: After a `start` with a count from 1 to MAX_IMG, `busy` is 1. Each byte with `byte_vld` high is taken as the next flash byte, beginning at offset 16. Directory entries are 12 bytes each, made of three little-endian 32-bit words in this order: identifier, image offset counted from flash byte 0, and image size in bytes.
- R4: An entry is a layout error (`err_code` = 2) in any of these cases: its offset is not a multiple of 4, its offset is below the end of the directory (16 + 12·count) or below the previous image's offset plus size, or its size is 0. `done` is 1 in the cycle after the entry's twelfth byte.
- R5: An identifier from 0x0004 to 0x0FFF in an entry that has no layout error gives `err_code` = 3, with `done` in the cycle after the entry's twelfth byte. Layout errors take priority.
- R6: Every byte after the directory that lies outside all images, up to the last image's end, must be 0x00. The first nonzero one gives `err_code` = 4, with `done` in the cycle after that byte.
- R7: The payload checksum is CRC-32 with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion, fed least significant bit first. It covers the first directory byte through the last image's last byte, including padding between images. `done` comes in the cycle after that last byte, with `err_code` = 0 on a match and 5 on a mismatch.
- R8: One cycle after `lk_req` with `lk_id`, `lk_hit` is 1 if an accepted entry of the current walk has that identifier, and `lk_off` and `lk_size` show that entry's values. If several entries match, the one with the lowest index wins. With no hit, or no request, all three outputs are 0. Only entries that passed R4 and R5 are accepted.
- R9: `done` lasts exactly one cycle, and `busy` is 0 while `done` is 1. `err_code` holds until the next `start`. Bytes offered while the block is idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (sampled only when idle) |
| img_count | input | 16 | Image count taken from the header |
| payload_crc | input | 32 | Expected payload checksum |
| byte_vld | input | 1 | `byte_data` holds the next flash byte |
| byte_data | input | 8 | Flash byte |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err_code | output | 3 | 0 ok, 1 too many images, 2 layout, 3 reserved id, 4 padding, 5 checksum |
| lk_req | input | 1 | Lookup request |
| lk_id | input | 32 | Identifier to look up |
| lk_hit | output | 1 | Lookup matched |
| lk_off | output | 32 | Matching image offset |
| lk_size | output | 32 | Matching image size |

## Verification
The assertions assume the following about the inputs. Bytes arrive in flash order, and the first byte arrives only after the cycle in which `start` was accepted. Once a walk ends, no more bytes belong to it. No offset plus size goes past 32 bits. The bench builds each layout in a 256-byte array and begins streaming at offset 16 right after `start`. It stops feeding at exactly the byte where its own model predicts the walk ends, and it inserts idle cycles only between bytes. Junk bytes are offered only while the block is idle, which tests that they are ignored.

// File: rtl/img_dir_walker.sv
`timescale 1ns/1ps
module img_dir_walker #(
  parameter int MAX_IMG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] img_count,
  input  logic [31:0] payload_crc,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  output logic        busy,
  output logic        done,
  output logic [2:0]  err_code,
  input  logic        lk_req,
  input  logic [31:0] lk_id,
  output logic        lk_hit,
  output logic [31:0] lk_off,
  output logic [31:0] lk_size
);
  localparam int IW = $clog2(MAX_IMG);
  localparam logic [IW:0] ONE = 1;
  localparam logic [31:0] POLY = 32'hEDB88320;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_DATA} st_t;
  st_t st;

  logic [31:0] pos, crc, exp_crc, bound, cur_id, cur_off;
  logic [23:0] sh;
  logic [3:0]  bsel;
  logic [IW:0] ent, k, cnt;
  logic [MAX_IMG-1:0] vld;
  logic [31:0] t_id [MAX_IMG];
  logic [31:0] t_off [MAX_IMG];
  logic [31:0] t_size [MAX_IMG];

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  wire [31:0]   w      = {byte_data, sh};
  wire [31:0]   crc_n  = crc_upd(crc, byte_data);
  wire [IW-1:0] es     = ent[IW-1:0];
  wire [IW-1:0] ks     = k[IW-1:0];
  wire [31:0]   c_off  = t_off[ks];
  wire [31:0]   c_end  = t_off[ks] + t_size[ks];
  wire          pad    = pos < c_off;
  wire          lay_bad = (cur_off[1:0] != 2'b00) || (cur_off < bound) || (w == 32'd0);
  wire          id_bad = (cur_id >= 32'h4) && (cur_id <= 32'hFFF);
  wire          ent_ok = (st == S_DIR) && byte_vld && (bsel == 4'd11) && !lay_bad && !id_bad;
  wire          last_ent = (ent + ONE) == cnt;
  wire          last_img = (k + ONE) == cnt;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; err_code <= 3'd0;
      pos <= 32'd0; crc <= 32'd0; exp_crc <= 32'd0; bound <= 32'd0;
      cur_id <= 32'd0; cur_off <= 32'd0; sh <= 24'd0; bsel <= 4'd0;
      ent <= '0; k <= '0; cnt <= '0; vld <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          err_code <= 3'd0;
          vld      <= '0;
          crc      <= 32'hFFFFFFFF;
          pos      <= 32'd16;
          bsel     <= 4'd0;
          ent      <= '0;
          k        <= '0;
          exp_crc  <= payload_crc;
          bound    <= 32'd16 + 32'd12 * {16'd0, img_count};
          cnt      <= img_count[IW:0];
          if (img_count > 16'(MAX_IMG)) begin
            done <= 1'b1; err_code <= 3'd1;
          end else if (img_count == 16'd0) begin
            done <= 1'b1; err_code <= (payload_crc != 32'd0) ? 3'd5 : 3'd0;
          end else begin
            st <= S_DIR;
          end
        end
        S_DIR: if (byte_vld) begin
          crc  <= crc_n;
          pos  <= pos + 32'd1;
          sh   <= w[31:8];
          bsel <= (bsel == 4'd11) ? 4'd0 : bsel + 4'd1;
          if (bsel == 4'd3) cur_id  <= w;
          if (bsel == 4'd7) cur_off <= w;
          if (bsel == 4'd11) begin
            if (lay_bad) begin
              done <= 1'b1; err_code <= 3'd2; st <= S_IDLE;
            end else if (id_bad) begin
              done <= 1'b1; err_code <= 3'd3; st <= S_IDLE;
            end else begin
              vld[es] <= 1'b1;
              bound   <= cur_off + w;
              ent     <= ent + ONE;
              if (last_ent) st <= S_DATA;
            end
          end
        end
        S_DATA: if (byte_vld) begin
          crc <= crc_n;
          pos <= pos + 32'd1;
          if (pad && byte_data != 8'd0) begin
            done <= 1'b1; err_code <= 3'd4; st <= S_IDLE;
          end else if (!pad && (pos + 32'd1) == c_end) begin
            if (last_img) begin
              done <= 1'b1; st <= S_IDLE;
              err_code <= (~crc_n != exp_crc) ? 3'd5 : 3'd0;
            end else begin
              k <= k + ONE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ent_ok) begin
      t_id[es]   <= cur_id;
      t_off[es]  <= cur_off;
      t_size[es] <= w;
    end
  end

  logic        m_hit;
  logic [31:0] m_off, m_size;
  always_comb begin
    m_hit = 1'b0; m_off = 32'd0; m_size = 32'd0;
    for (int i = MAX_IMG - 1; i >= 0; i--) begin
      if (vld[i] && t_id[i] == lk_id) begin
        m_hit = 1'b1; m_off = t_off[i]; m_size = t_size[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit <= 1'b0; lk_off <= 32'd0; lk_size <= 32'd0;
    end else begin
      lk_hit  <= lk_req && m_hit;
      lk_off  <= (lk_req && m_hit) ? m_off : 32'd0;
      lk_size <= (lk_req && m_hit) ? m_size : 32'd0;
    end
  end

  // R2
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && img_count > 16'(MAX_IMG)) |=> (done && err_code == 3'd1));
  // R3
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_vld) |=> (pos == $past(pos) + 32'd1));
  // R4
  data_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (c_off[1:0] == 2'b00 && t_size[ks] != 32'd0));
  // R8
  lk_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_req));
  // R8
  accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) <= int'(cnt));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_code) |-> (done || $past(start && !busy)));
endmodule

// File: tb/sim_img_dir_walker.sv
`timescale 1ns/1ps
module sim_img_dir_walker;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, byte_vld = 1'b0, lk_req = 1'b0;
  logic [15:0] img_count = 16'd0;
  logic [31:0] payload_crc = 32'd0, lk_id = 32'd0;
  logic [7:0]  byte_data = 8'd0;
  logic        busy, done, lk_hit;
  logic [2:0]  err_code;
  logic [31:0] lk_off, lk_size;

  img_dir_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .img_count(img_count),
    .payload_crc(payload_crc), .byte_vld(byte_vld), .byte_data(byte_data),
    .busy(busy), .done(done), .err_code(err_code), .lk_req(lk_req),
    .lk_id(lk_id), .lk_hit(lk_hit), .lk_off(lk_off), .lk_size(lk_size));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0]  fl [256];
  int          n = 0;
  logic [31:0] ids [8];
  logic [31:0] offs [8];
  logic [31:0] sizes [8];
  int          poke_at = -1;
  logic [7:0]  poke_val = 8'd0;
  int          m_term, m_err, m_acc;
  bit          m_now;
  logic [31:0] m_crc;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string rq(input int e);
    case (e)
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] ref_crc(input int lo, input int hi);
    logic [31:0] c = 32'hFFFFFFFF;
    bit fb;
    for (int p = lo; p < hi; p++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ fl[p][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic set(input int i, input logic [31:0] id, input logic [31:0] off, input logic [31:0] sz);
    ids[i] = id; offs[i] = off; sizes[i] = sz;
  endtask

  task automatic build();
    for (int p = 0; p < 256; p++) fl[p] = 8'd0;
    for (int p = 0; p < 16; p++) fl[p] = 8'(8'hA0 + p);
    for (int i = 0; i < n && i < 8; i++)
      for (int b = 0; b < 4; b++) begin
        fl[16 + 12*i + b]     = ids[i][8*b +: 8];
        fl[16 + 12*i + 4 + b] = offs[i][8*b +: 8];
        fl[16 + 12*i + 8 + b] = sizes[i][8*b +: 8];
      end
    for (int i = 0; i < n && i < 8; i++)
      for (int j = 0; j < int'(sizes[i]); j++)
        if (int'(offs[i]) + j < 256) fl[int'(offs[i]) + j] = 8'(i*53 + j*7 + 3);
    if (poke_at >= 0) fl[poke_at] = poke_val;
  endtask

  task automatic model();
    logic [31:0] bound, last;
    bit cov;
    m_now = 0; m_err = 0; m_acc = 0; m_term = 0; m_crc = 32'd0;
    if (n > 8) begin m_now = 1; m_err = 1; return; end
    if (n == 0) begin m_now = 1; return; end
    bound = 32'(16 + 12*n);
    for (int i = 0; i < n; i++) begin
      if (offs[i][1:0] != 2'b00 || offs[i] < bound || sizes[i] == 0) begin
        m_err = 2; m_term = 16 + 12*i + 11; m_acc = i; return;
      end
      if (ids[i] >= 32'h4 && ids[i] <= 32'hFFF) begin
        m_err = 3; m_term = 16 + 12*i + 11; m_acc = i; return;
      end
      bound = offs[i] + sizes[i];
    end
    m_acc = n;
    last = offs[n-1] + sizes[n-1];
    for (int p = 16 + 12*n; p < int'(last); p++) begin
      cov = 0;
      for (int i = 0; i < n; i++)
        if (p >= int'(offs[i]) && p < int'(offs[i] + sizes[i])) cov = 1;
      if (!cov && fl[p] != 8'd0) begin m_err = 4; m_term = p; return; end
    end
    m_crc = ref_crc(16, int'(last));
    m_term = int'(last) - 1;
  endtask

  task automatic run(input logic [31:0] cx, input bit gaps);
    int e;
    build();
    model();
    e = m_err;
    if (e == 0) e = (cx != 0) ? 5 : 0;
    @(negedge clk);
    start = 1'b1; img_count = 16'(n); payload_crc = m_crc ^ cx;
    @(negedge clk);
    start = 1'b0;
    if (m_now) begin
      chk(done === 1'b1 && err_code == 3'(e), rq(e), "immediate done/err", {28'd0, done, err_code}, 32'(8 + e));
    end else begin
      chk(busy === 1'b1 && done === 1'b0, "R3", "busy after start", {31'd0, busy}, 32'd1);
      for (int p = 16; p <= m_term; p++) begin
        byte_vld = 1'b1; byte_data = fl[p];
        @(negedge clk);
        byte_vld = 1'b0;
        if (p == m_term)
          chk(done === 1'b1 && err_code == 3'(e), rq(e), "end of walk done/err", {28'd0, done, err_code}, 32'(8 + e));
        else
          chk(done === 1'b0 && busy === 1'b1, rq(e), "walk in progress", {30'd0, done, busy}, 32'd1);
        if (gaps && (p % 3 == 0) && p != m_term) begin
          @(negedge clk);
          chk(done === 1'b0 && busy === 1'b1, "R3", "idle gap", {30'd0, done, busy}, 32'd1);
        end
      end
    end
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && err_code == 3'(e), "R9", "result held", {27'd0, done, busy, err_code}, 32'(e));
  endtask

  task automatic lk(input logic [31:0] id);
    bit h = 0;
    logic [31:0] eo = 32'd0, es = 32'd0;
    for (int i = m_acc - 1; i >= 0; i--)
      if (ids[i] == id) begin h = 1; eo = offs[i]; es = sizes[i]; end
    @(negedge clk);
    lk_req = 1'b1; lk_id = id;
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_hit === h, "R8", "lookup hit", {31'd0, lk_hit}, {31'd0, h});
    chk(lk_off == eo, "R8", "lookup offset", lk_off, eo);
    chk(lk_size == es, "R8", "lookup size", lk_size, es);
    @(negedge clk);
    chk(lk_hit === 1'b0 && lk_off == 0, "R8", "no request no hit", {31'd0, lk_hit}, 32'd0);
  endtask

  task automatic idle_bytes();
    for (int i = 0; i < 5; i++) begin
      byte_vld = 1'b1; byte_data = 8'hFF;
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R9", "idle bytes ignored", {30'd0, busy, done}, 32'd0);
    end
    byte_vld = 1'b0;
  endtask

  task automatic base4();
    n = 4;
    set(0, 32'h1, 64, 10);
    set(1, 32'h2, 76, 7);
    set(2, 32'h3, 84, 4);
    set(3, 32'h1000, 96, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && lk_hit === 1'b0 && err_code == 3'd0,
        "R1", "reset state", {28'd0, busy, done, lk_hit, |err_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && err_code == 3'd0, "R1", "after reset", {29'd0, err_code}, 32'd0);

    base4();
    idle_bytes();
    run(32'd0, 1'b0);
    lk(32'h2); lk(32'h1000); lk(32'h5); lk(32'h1);
    run(32'h1, 1'b1);
    run(32'd0, 1'b1);
    poke_at = 90; poke_val = 8'h5A; run(32'd0, 1'b0);
    poke_at = 74; poke_val = 8'h01; run(32'd0, 1'b1);
    poke_at = -1;

    set(1, 32'h2, 78, 7); run(32'd0, 1'b0);
    lk(32'h1); lk(32'h2);
    base4(); set(0, 32'h1, 60, 10); run(32'd0, 1'b0);
    base4(); set(2, 32'h800, 84, 4); run(32'd0, 1'b0);
    lk(32'h2); lk(32'h800);
    base4(); set(2, 32'h3, 80, 4); run(32'd0, 1'b0);
    base4(); set(1, 32'h2, 76, 0); run(32'd0, 1'b1);

    n = 9; run(32'd0, 1'b0);
    n = 0; run(32'd0, 1'b0);
    n = 0; run(32'd5, 1'b0);

    n = 2;
    set(0, 32'h2000, 40, 4);
    set(1, 32'h2000, 44, 8);
    run(32'd0, 1'b1);
    lk(32'h2000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule